// File: doc/BRIEF.md
# Maskable BCD Alarm Comparator

This block watches a running calendar that arrives as BCD fields (seconds, minutes, hours with an afternoon bit, day of month and weekday) together with a one-cycle strobe that marks each new second. On every strobe, and only while the alarm is enabled, it compares the calendar against a stored 32-bit alarm word. Each of the four alarm fields carries its own ignore bit. The date field can be read either as a day of month or as a weekday, and a selector bit picks which.

When every field that is not ignored matches, a sticky alarm flag is set. The flag stays set until it is explicitly cleared. An interrupt output follows the flag, gated by an interrupt enable. The alarm word can only be loaded while a write-permit flag is high. That flag drops as soon as the alarm is enabled, and it comes back a fixed number of clock cycles after the alarm is disabled. Software must therefore disable the alarm, wait for the permit, write the word, and then re-enable the alarm.

Top module: `bcd_alarm_cmp`

## Requirements
- R1: While reset is high, and on the first cycle after reset, `alm_wr_ok`, `alarm_flag` and `alarm_irq` are 0 and `alm_word` is 0.
- R2: `alm_wr_ok` is 0 in the cycle after any clock edge that samples `alarm_en` high. It becomes 1 after WR_DELAY consecutive edges (default 2) that sample `alarm_en` low.
- R3: A write request (`alm_wr` high at an edge) loads `alm_wdata` into `alm_word` only if `alm_wr_ok` was 1 before that edge. Otherwise the write is ignored and `alm_word` keeps its value.
- R4: A match is evaluated only at an edge where `cal_tick` and `alarm_en` are both high. A matching calendar with no strobe, or with the alarm disabled, leaves the flag unchanged.
- R5: Time fields use this layout: seconds in word bits 6:0, minutes in bits 14:8, hours in bits 21:16 and the PM bit in bit 22. The PM bit is compared with `cal_pm`.
- R6: Bits 7, 15, 23 and 31 are the ignore bits for seconds, minutes, hours (together with PM) and date. A set ignore bit always counts that field as matched. With bit 31 set, the alarm fires on any day.
- R7: With bit 30 clear, bits 29:24 are compared with `cal_mday`. With bit 30 set, bits 27:24 hold a weekday code (1 = Monday to 7 = Sunday) that is compared with `cal_wday`. A weekday code of 0 never matches.
- R8: `alarm_flag` is set at the edge that samples a successful match. It then stays 1 until an edge samples `alarm_flag_clr` high, which forces it to 0 even if a match is sampled at the same edge.
- R9: `alarm_irq` equals `alarm_flag` ANDed with the `alarm_irq_en` value sampled at the same edge, and it is registered alongside the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cal_tick | input | 1 | One-cycle strobe, once per calendar second |
| cal_sec | input | 7 | Current seconds, BCD |
| cal_min | input | 7 | Current minutes, BCD |
| cal_hour | input | 6 | Current hours, BCD |
| cal_pm | input | 1 | Current afternoon indicator |
| cal_mday | input | 6 | Current day of month, BCD |
| cal_wday | input | 3 | Current weekday, 1 = Monday to 7 = Sunday |
| alarm_en | input | 1 | Alarm enable |
| alarm_irq_en | input | 1 | Alarm interrupt enable |
| alm_wr | input | 1 | Alarm word write request |
| alm_wdata | input | 32 | Alarm word write data |
| alarm_flag_clr | input | 1 | Clear the sticky alarm flag |
| alm_word | output | 32 | Stored alarm word |
| alm_wr_ok | output | 1 | Alarm word may be written |
| alarm_flag | output | 1 | Sticky alarm flag |
| alarm_irq | output | 1 | Alarm interrupt |

## Verification
The assertions assume that `cal_tick` is a single-cycle pulse. They also assume that the flag clear and the write request are ordinary synchronous inputs that may coincide with a strobe. They rely on no particular ordering of software steps, so a write attempted while the alarm is enabled is legal stimulus and must be ignored. The stimulus draws calendar and alarm field values from small BCD sets, so that matches, partial matches and ignored fields all occur often. It reloads the alarm word only through the disable, wait-for-permit, write sequence, except where it deliberately tries forbidden writes to exercise the ignore path.

// File: rtl/alm_pkg.sv
package alm_pkg;
  localparam int FLD_STRIDE = 8;
  localparam int TFLD_W     = 7;
  localparam int NUM_TFLD   = 3;
  localparam int DAY_LSB    = 24;
  localparam int MDAY_W     = 6;
  localparam int WDAY_W     = 4;
  localparam int CAL_WDAY_W = 3;
  localparam int DSEL_BIT   = 30;
  localparam int DMSK_BIT   = 31;
  localparam int WORD_W     = 32;

  typedef struct packed {
    logic [6:0] sec;
    logic [6:0] min;
    logic       pm;
    logic [5:0] hour;
    logic [5:0] mday;
    logic [CAL_WDAY_W-1:0] wday;
  } cal_t;
endpackage

// File: rtl/alm_field_eq.sv
module alm_field_eq #(
  parameter int W = 7
) (
  input  logic [W-1:0] want,
  input  logic [W-1:0] have,
  input  logic         ignore,
  output logic         hit
);
  always_comb hit = ignore | (want == have);
endmodule

// File: rtl/alm_match.sv
module alm_match
  import alm_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  input  cal_t              now,
  output logic              hit
);
  logic [NUM_TFLD-1:0][TFLD_W-1:0] cur_f;
  logic [NUM_TFLD-1:0]             t_hit;
  logic mday_eq, wday_eq, day_hit;

  always_comb begin
    cur_f[0] = now.sec;
    cur_f[1] = now.min;
    cur_f[2] = {now.pm, now.hour};
  end

  for (genvar i = 0; i < NUM_TFLD; i++) begin : g_tfld
    alm_field_eq #(.W(TFLD_W)) u_eq (
      .want  (word[i*FLD_STRIDE +: TFLD_W]),
      .have  (cur_f[i]),
      .ignore(word[i*FLD_STRIDE + TFLD_W]),
      .hit   (t_hit[i])
    );
  end

  alm_field_eq #(.W(MDAY_W)) u_mday (
    .want  (word[DAY_LSB +: MDAY_W]),
    .have  (now.mday),
    .ignore(1'b0),
    .hit   (mday_eq)
  );

  alm_field_eq #(.W(WDAY_W)) u_wday (
    .want  (word[DAY_LSB +: WDAY_W]),
    .have  ({1'b0, now.wday}),
    .ignore(1'b0),
    .hit   (wday_eq)
  );

  always_comb begin
    if (word[DMSK_BIT])      day_hit = 1'b1;
    else if (word[DSEL_BIT]) day_hit = wday_eq & (word[DAY_LSB +: WDAY_W] != '0);
    else                     day_hit = mday_eq;
    hit = (&t_hit) & day_hit;
  end
endmodule

// File: rtl/alm_wr_gate.sv
module alm_wr_gate #(
  parameter int WR_DELAY = 2,
  parameter int WORD_W   = 32,
  localparam int CW      = $clog2(WR_DELAY + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              alarm_en,
  input  logic              wr_req,
  input  logic [WORD_W-1:0] wr_data,
  output logic              wr_ok,
  output logic [WORD_W-1:0] word
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      wr_ok <= 1'b0;
      word  <= '0;
    end else begin
      if (alarm_en) begin
        cnt   <= '0;
        wr_ok <= 1'b0;
      end else begin
        if (cnt != CW'(WR_DELAY)) cnt <= cnt + 1'b1;
        wr_ok <= (cnt >= CW'(WR_DELAY - 1));
      end
      if (wr_req && wr_ok) word <= wr_data;
    end
  end

  assert_wr_ignored_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_req && !wr_ok) |=> $stable(word));
  assert_permit_drop_R2: assert property (@(posedge clk) disable iff (rst)
    alarm_en |=> !wr_ok);
  assert_permit_needs_idle_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(wr_ok) |-> $past(!alarm_en));
endmodule

// File: rtl/alm_event.sv
module alm_event (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic alarm_en,
  input  logic irq_en,
  input  logic hit,
  input  logic flag_clr,
  output logic flag,
  output logic irq
);
  logic flag_n;

  always_comb begin
    if (flag_clr) flag_n = 1'b0;
    else          flag_n = flag | (tick & alarm_en & hit);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag <= 1'b0;
      irq  <= 1'b0;
    end else begin
      flag <= flag_n;
      irq  <= flag_n & irq_en;
    end
  end

  assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    (flag && !flag_clr) |=> flag);
  assert_flag_clear_R8: assert property (@(posedge clk) disable iff (rst)
    flag_clr |=> !flag);
  assert_set_on_tick_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(flag) |-> $past(tick && alarm_en));
  assert_irq_follows_flag_R9: assert property (@(posedge clk) disable iff (rst)
    irq |-> flag);
endmodule

// File: rtl/bcd_alarm_cmp.sv
module bcd_alarm_cmp
  import alm_pkg::*;
#(
  parameter int WR_DELAY = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        cal_tick,
  input  logic [6:0]  cal_sec,
  input  logic [6:0]  cal_min,
  input  logic [5:0]  cal_hour,
  input  logic        cal_pm,
  input  logic [5:0]  cal_mday,
  input  logic [2:0]  cal_wday,
  input  logic        alarm_en,
  input  logic        alarm_irq_en,
  input  logic        alm_wr,
  input  logic [31:0] alm_wdata,
  input  logic        alarm_flag_clr,
  output logic [31:0] alm_word,
  output logic        alm_wr_ok,
  output logic        alarm_flag,
  output logic        alarm_irq
);
  cal_t now;
  logic hit;

  always_comb begin
    now.sec  = cal_sec;
    now.min  = cal_min;
    now.pm   = cal_pm;
    now.hour = cal_hour;
    now.mday = cal_mday;
    now.wday = cal_wday;
  end

  alm_wr_gate #(.WR_DELAY(WR_DELAY), .WORD_W(WORD_W)) u_gate (
    .clk     (clk),
    .rst     (rst),
    .alarm_en(alarm_en),
    .wr_req  (alm_wr),
    .wr_data (alm_wdata),
    .wr_ok   (alm_wr_ok),
    .word    (alm_word)
  );

  alm_match u_match (
    .word(alm_word),
    .now (now),
    .hit (hit)
  );

  alm_event u_evt (
    .clk     (clk),
    .rst     (rst),
    .tick    (cal_tick),
    .alarm_en(alarm_en),
    .irq_en  (alarm_irq_en),
    .hit     (hit),
    .flag_clr(alarm_flag_clr),
    .flag    (alarm_flag),
    .irq     (alarm_irq)
  );

  assert_wday_zero_R7: assert property (@(posedge clk) disable iff (rst)
    (alm_word[DSEL_BIT] && !alm_word[DMSK_BIT] && alm_word[27:24] == 4'd0)
    |-> !hit);
  assert_no_set_masked_off_R4: assert property (@(posedge clk) disable iff (rst)
    (!alarm_en && !alarm_flag) |=> !alarm_flag);
endmodule

// File: tb/tb_bcd_alarm_cmp.sv
module tb_bcd_alarm_cmp;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cal_tick = 0, cal_pm = 0, alarm_en = 0, alarm_irq_en = 0;
  logic alm_wr = 0, alarm_flag_clr = 0;
  logic [6:0] cal_sec = 0, cal_min = 0;
  logic [5:0] cal_hour = 0, cal_mday = 0;
  logic [2:0] cal_wday = 0;
  logic [31:0] alm_wdata = 0;
  logic [31:0] alm_word;
  logic alm_wr_ok, alarm_flag, alarm_irq;

  int n_chk = 0, n_fail = 0;
  bit started = 0, done = 0;

  int m_cnt = 0;
  bit m_ok = 0, m_flag = 0, m_irq = 0;
  logic [31:0] m_word = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bcd_alarm_cmp dut (
    .clk(clk), .rst(rst), .cal_tick(cal_tick), .cal_sec(cal_sec),
    .cal_min(cal_min), .cal_hour(cal_hour), .cal_pm(cal_pm),
    .cal_mday(cal_mday), .cal_wday(cal_wday), .alarm_en(alarm_en),
    .alarm_irq_en(alarm_irq_en), .alm_wr(alm_wr), .alm_wdata(alm_wdata),
    .alarm_flag_clr(alarm_flag_clr), .alm_word(alm_word),
    .alm_wr_ok(alm_wr_ok), .alarm_flag(alarm_flag), .alarm_irq(alarm_irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference of the alarm decision
  function automatic bit ref_hit(input logic [31:0] w);
    bit s, m, h, d;
    s = w[7]  || (w[6:0] == cal_sec);
    m = w[15] || (w[14:8] == cal_min);
    h = w[23] || ((w[21:16] == cal_hour) && (w[22] == cal_pm));
    if (w[31])      d = 1;
    else if (w[30]) d = (int'(w[27:24]) != 0) && (int'(w[27:24]) == int'(cal_wday));
    else            d = (w[29:24] == cal_mday);
    return s && m && h && d;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_cnt = 0; m_ok = 0; m_word = 0; m_flag = 0; m_irq = 0;
    end else begin
      bit nf;
      nf = alarm_flag_clr ? 1'b0 : (m_flag || (cal_tick && alarm_en && ref_hit(m_word)));
      if (alm_wr && m_ok) m_word = alm_wdata;
      if (alarm_en) m_cnt = 0;
      else if (m_cnt < 2) m_cnt = m_cnt + 1;
      m_ok = (m_cnt >= 2);
      m_flag = nf;
      m_irq = nf && alarm_irq_en;
    end
  end

  always @(negedge clk) begin
    if (started && !rst && !done) begin
      chk("R2 model wr_ok", {31'd0, alm_wr_ok}, {31'd0, m_ok});
      chk("R3 model word", alm_word, m_word);
      chk("R8 model flag", {31'd0, alarm_flag}, {31'd0, m_flag});
      chk("R9 model irq", {31'd0, alarm_irq}, {31'd0, m_irq});
    end
  end

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic set_time(input logic [5:0] hr, input logic pm, input logic [6:0] mn,
                          input logic [6:0] sc, input logic [5:0] md, input logic [2:0] wd);
    cal_hour = hr; cal_pm = pm; cal_min = mn; cal_sec = sc; cal_mday = md; cal_wday = wd;
  endtask

  task automatic tick();
    cal_tick = 1; cyc(); cal_tick = 0;
  endtask

  task automatic program_word(input logic [31:0] w);
    alarm_en = 0;
    cyc();
    for (int k = 0; k < 20 && !alm_wr_ok; k++) cyc();
    alm_wr = 1; alm_wdata = w;
    cyc();
    alm_wr = 0;
    alarm_en = 1;
  endtask

  function automatic logic [6:0] pick3(input logic [6:0] a, b, c);
    int r = $urandom % 3;
    return (r == 0) ? a : (r == 1) ? b : c;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    repeat (3) cyc();
    chk("R1 reset wr_ok", {31'd0, alm_wr_ok}, 0);
    chk("R1 reset flag", {31'd0, alarm_flag}, 0);
    chk("R1 reset irq", {31'd0, alarm_irq}, 0);
    chk("R1 reset word", alm_word, 0);
    rst = 0; started = 1;
    alm_wr = 1; alm_wdata = 32'hDEAD_BEEF;
    cyc();
    chk("R1 first cycle wr_ok", {31'd0, alm_wr_ok}, 0);
    chk("R3 early write ignored", alm_word, 0);
    alm_wr = 0;
    cyc();
    chk("R2 permit after two idle edges", {31'd0, alm_wr_ok}, 1);
    alm_wr = 1; alm_wdata = 32'h8008_1530;
    cyc();
    alm_wr = 0;
    chk("R3 permitted write", alm_word, 32'h8008_1530);
    alarm_en = 1; alarm_irq_en = 1;
    cyc();
    chk("R2 permit drops when enabled", {31'd0, alm_wr_ok}, 0);
    // R5: one second early, no match
    set_time(6'h08, 0, 7'h15, 7'h29, 6'h03, 3'd4);
    tick();
    chk("R5 seconds differ", {31'd0, alarm_flag}, 0);
    cal_sec = 7'h30;
    cyc();
    chk("R4 match without strobe", {31'd0, alarm_flag}, 0);
    tick();
    chk("R5 R6 match with date ignored", {31'd0, alarm_flag}, 1);
    chk("R9 irq with enable", {31'd0, alarm_irq}, 1);
    alarm_irq_en = 0;
    cyc();
    chk("R9 irq gated off", {31'd0, alarm_irq}, 0);
    chk("R8 flag holds", {31'd0, alarm_flag}, 1);
    alarm_irq_en = 1; alarm_flag_clr = 1;
    tick();
    alarm_flag_clr = 0;
    chk("R8 clear wins over match", {31'd0, alarm_flag}, 0);
    cal_pm = 1;
    tick();
    chk("R5 PM bit differs", {31'd0, alarm_flag}, 0);
    // R7 weekday mode, hours and minutes ignored
    program_word(32'h4380_8000);
    set_time(6'h17, 0, 7'h42, 7'h00, 6'h09, 3'd2);
    tick();
    chk("R7 weekday differs", {31'd0, alarm_flag}, 0);
    cal_wday = 3'd3;
    tick();
    chk("R6 R7 weekday match", {31'd0, alarm_flag}, 1);
    alarm_flag_clr = 1; cyc(); alarm_flag_clr = 0;
    program_word(32'h4080_8000);
    cal_wday = 3'd0;
    tick();
    chk("R7 weekday zero never matches", {31'd0, alarm_flag}, 0);
    // R7 day of month mode, seconds ignored
    program_word(32'h2123_0580);
    set_time(6'h23, 0, 7'h05, 7'h44, 6'h22, 3'd5);
    tick();
    chk("R7 mday differs", {31'd0, alarm_flag}, 0);
    cal_mday = 6'h21;
    alarm_en = 0;
    tick();
    chk("R4 disabled alarm ignores match", {31'd0, alarm_flag}, 0);
    alarm_en = 1;
    cyc();
    alm_wr = 1; alm_wdata = 32'h0;
    cyc();
    alm_wr = 0;
    chk("R3 write while enabled ignored", alm_word, 32'h2123_0580);
    tick();
    chk("R7 mday match", {31'd0, alarm_flag}, 1);
    alarm_flag_clr = 1; cyc(); alarm_flag_clr = 0;
    // Mixed stimulus, checked against the reference on every clock
    for (int i = 0; i < 1500; i++) begin
      if (i % 60 == 0) begin
        bit ws = $urandom % 2;
        logic [3:0] wd = 4'($urandom % 4);
        logic [5:0] md = ($urandom % 2) ? 6'h21 : 6'h01;
        program_word({($urandom % 4) == 0, ws, ws ? {2'b00, wd} : md,
                      ($urandom % 4) == 0, 1'($urandom % 2),
                      ($urandom % 2) ? 6'h08 : 6'h23,
                      ($urandom % 4) == 0, ($urandom % 2) ? 7'h05 : 7'h15,
                      ($urandom % 4) == 0, pick3(7'h00, 7'h30, 7'h59)});
      end
      set_time(($urandom % 2) ? 6'h08 : 6'h23, 1'($urandom % 2),
               ($urandom % 2) ? 7'h05 : 7'h15, pick3(7'h00, 7'h30, 7'h59),
               ($urandom % 2) ? 6'h21 : 6'h01, 3'($urandom % 4));
      cal_tick = (i % 3 == 0);
      alarm_flag_clr = ($urandom % 9 == 0);
      alarm_irq_en = ($urandom % 5 != 0);
      alm_wr = ($urandom % 13 == 0);
      alm_wdata = $urandom;
      if ($urandom % 40 == 0) alarm_en = ~alarm_en;
      cyc();
    end
    cal_tick = 0; alarm_flag_clr = 0; alm_wr = 0;
    cyc();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule